// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block runs entirely on the master audio clock (MCLK). From it, the block produces a bit clock (BCLK) and a left/right frame clock (LRC). Each clock is given as a level output and as single-cycle clock-enable strobes, so the logic downstream can stay in the MCLK domain and never needs a derived clock net.

The bit clock can be set up in two ways:
- **Divide mode:** MCLK is divided by a power of two, from 1 to 16.
- **Multiply mode:** BCLK runs at 32 or 64 bit periods per frame. The block derives the MCLK divisor as the FS ratio divided by the bits-per-frame value.

The FS ratio is the number of MCLK cycles per sample, for example 128, 192, 256, 272 or 1536. It sets the frame length, so LRC runs at exactly the sample rate.

A new configuration is captured with a one-cycle load pulse. The load restarts both phase counters. The block checks that the configuration is consistent, meaning every half frame holds a whole number of bit periods. If it is not, the block raises an error flag and holds every clock output low.

Top module: `audio_clkgen`

## Requirements
- R1: After reset the block runs the default configuration: divide mode, divisor 4, FS 256. In the first cycle after reset is released, the BCLK falling strobe and the frame strobe are high, and BCLK and LRC are low.
- R2: In divide mode (`cfg_mode`=0), the divisor is D = 2^`cfg_div_log2`. BCLK has a period of D MCLK cycles. It is low for the first D/2 cycles (integer division) and high for the rest. `bclk_fall_stb` marks the first cycle of each period, and `bclk_rise_stb` marks the first high cycle.
- R3: In multiply mode (`cfg_mode`=1), the divisor is D = FS/32 when `cfg_bpf64`=0 and D = FS/64 when `cfg_bpf64`=1. The BCLK waveform follows the same rule as in R2, so a non-power-of-two D such as 3 or 24 is allowed.
- R4: When D equals 1, `bclk` is constantly high, and both `bclk_fall_stb` and `bclk_rise_stb` are high in every cycle.
- R5: A frame lasts FS MCLK cycles. LRC is low for the first FS/2 cycles and high for the next FS/2. `frame_stb` marks the first cycle of the frame, and `half_stb` marks the first cycle with LRC high.
- R6: Every LRC transition coincides with a BCLK falling strobe.
- R7: In divide mode the configuration is inconsistent if FS is zero, if `cfg_div_log2` exceeds 4, or if FS/2 is not a whole multiple of D. An inconsistent configuration drives `config_error` high.
- R8: In multiply mode the configuration is inconsistent if FS is zero or FS is not a whole multiple of the bits-per-frame value. An inconsistent configuration drives `config_error` high.
- R9: While `config_error` is high, `bclk`, `lrc` and all strobes are low.
- R10: The cycle after a load pulse is phase zero of both the bit period and the frame, so LRC is low and, if the configuration is valid, `frame_stb` is high.
- R11: Configuration inputs have no effect unless `cfg_load` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock (MCLK) |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Single-cycle pulse that captures the configuration inputs |
| cfg_mode | input | 1 | 0 selects divide mode, 1 selects multiply mode |
| cfg_div_log2 | input | 3 | log2 of the BCLK divisor in divide mode |
| cfg_bpf64 | input | 1 | Multiply mode: 0 selects 32 bits per frame, 1 selects 64 |
| cfg_fs | input | FS_W (12) | FS ratio: MCLK cycles per frame |
| bclk | output | 1 | Bit clock level |
| bclk_fall_stb | output | 1 | First cycle of each bit period (BCLK falls) |
| bclk_rise_stb | output | 1 | First cycle of the BCLK high phase |
| lrc | output | 1 | Frame clock level: low for the first half, high for the second |
| frame_stb | output | 1 | First cycle of each frame |
| half_stb | output | 1 | First cycle of the second half-frame |
| config_error | output | 1 | The loaded configuration is inconsistent |

## Verification
The assertions check on every cycle that:
- the phase counters stay inside their periods;
- each LRC transition and frame or half strobe falls on a BCLK falling strobe;
- an error flag silences every output;
- a load pulse restarts the frame with LRC low;
- the error flag cannot change without a load.

Only the bench scenarios can show the exact waveforms, that is, the period of each divisor, the duty split for odd divisors such as 3, and the half-frame lengths for ratios such as 272 and 1536. They also show which configurations are accepted or rejected, and that inputs changed without a load leave the running pattern untouched.

// File: rtl/audio_clkgen_pkg.sv
// Shared definitions for the audio clock generator.
package audio_clkgen_pkg;

    // Width of the divisor-select field.
    localparam int SEL_W = 3;

    // Source of the bit-clock divisor.
    typedef enum logic {
        MODE_DIV = 1'b0,   // MCLK divided by a power of two
        MODE_MUL = 1'b1    // fixed bits per frame, divisor = FS / bits
    } clk_mode_e;

endpackage

// File: rtl/aclk_cfg_decode.sv
// Configuration decoder.
// Turns a stored configuration into the MCLK-cycle divisor of one bit period.
// Flags a configuration in which a half frame does not hold a whole number of
// bit periods.
// Assumes: the bits-per-frame values and the divide-mode divisors are powers of
// two, so every consistency test reduces to checking low-order bits of FS.
// Purely combinational.
module aclk_cfg_decode
    import audio_clkgen_pkg::*;
#(
    parameter int FS_W         = 12,
    parameter int MAX_DIV_LOG2 = 4,
    parameter int BPF_LO_LOG2  = 5,
    parameter int BPF_HI_LOG2  = 6
) (
    input  logic             mode,
    input  logic [SEL_W-1:0] div_log2,
    input  logic             bpf_hi,
    input  logic [FS_W-1:0]  fs,
    output logic [FS_W-1:0]  div,
    output logic             err
);
    localparam int SH_W = $clog2(FS_W + 1) + 1;

    logic [SH_W-1:0] shamt;
    logic [FS_W-1:0] low_mask;
    logic            low_bits_set;

    // Pick the shift, then test the FS bits that must be zero for consistency.
    always_comb begin
        if (mode == logic'(MODE_DIV)) begin
            shamt = SH_W'(div_log2) + SH_W'(1);
        end else begin
            shamt = bpf_hi ? SH_W'(BPF_HI_LOG2) : SH_W'(BPF_LO_LOG2);
        end
        low_mask     = (FS_W'(1) << shamt) - FS_W'(1);
        low_bits_set = |(fs & low_mask);
        if (mode == logic'(MODE_DIV)) begin
            div = FS_W'(1) << div_log2;
            err = (fs == '0) || (div_log2 > SEL_W'(MAX_DIV_LOG2)) || low_bits_set;
        end else begin
            div = fs >> shamt;
            err = (fs == '0) || low_bits_set;
        end
    end

endmodule

// File: rtl/aclk_phase_ctr.sv
// Phase counter.
// Counts MCLK cycles modulo a runtime period and reports the period start,
// the half point and whether the count is in the upper half.
// Assumes: period >= 1 whenever run is high. The count is held at zero while
// run is low or restart is high.
module aclk_phase_ctr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] period,
    output logic         at_zero,
    output logic         at_half,
    output logic         upper
);
    logic [W-1:0] cnt;
    logic [W-1:0] half;

    assign half = period >> 1;

    // Advance the phase, wrapping at the period, and clear it on restart or idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || !run) begin
            cnt <= '0;
        end else if (cnt == period - W'(1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + W'(1);
        end
    end

    // Decode the phase points used by the outputs.
    always_comb begin
        at_zero = run && (cnt == '0);
        at_half = run && (cnt == half);
        upper   = run && (cnt >= half);
    end

    // R2 / R5: the phase never leaves its period while running
    p_phase_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < period));

    // R10: a restart returns the phase to zero
    p_restart_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));

endmodule

// File: rtl/audio_clkgen.sv
// Audio bit and frame clock generator.
// Derives BCLK and LRC from MCLK as level outputs and clock-enable strobes.
// The bit divisor comes either from a power-of-two MCLK divide or from FS
// divided by the bits per frame. LRC spans FS MCLK cycles.
// Assumes: everything runs in the MCLK domain. A configuration takes effect
// only with cfg_load, and the load also restarts both phase counters.
module audio_clkgen
    import audio_clkgen_pkg::*;
#(
    parameter int FS_W         = 12,
    parameter int MAX_DIV_LOG2 = 4,
    parameter int BPF_LO_LOG2  = 5,
    parameter int BPF_HI_LOG2  = 6,
    parameter int DEF_FS       = 256,
    parameter int DEF_DIV_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic             cfg_mode,
    input  logic [SEL_W-1:0] cfg_div_log2,
    input  logic             cfg_bpf64,
    input  logic [FS_W-1:0]  cfg_fs,
    output logic             bclk,
    output logic             bclk_fall_stb,
    output logic             bclk_rise_stb,
    output logic             lrc,
    output logic             frame_stb,
    output logic             half_stb,
    output logic             config_error
);
    logic             mode_q;
    logic [SEL_W-1:0] div_log2_q;
    logic             bpf_q;
    logic [FS_W-1:0]  fs_q;
    logic [FS_W-1:0]  bit_div;
    logic             cfg_bad;
    logic             run;
    logic             b_zero, b_half, b_upper;
    logic             f_zero, f_half, f_upper;

    // Hold the active configuration; it changes only on a load pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= logic'(MODE_DIV);
            div_log2_q <= SEL_W'(DEF_DIV_LOG2);
            bpf_q      <= 1'b0;
            fs_q       <= FS_W'(DEF_FS);
        end else if (cfg_load) begin
            mode_q     <= cfg_mode;
            div_log2_q <= cfg_div_log2;
            bpf_q      <= cfg_bpf64;
            fs_q       <= cfg_fs;
        end
    end

    aclk_cfg_decode #(
        .FS_W(FS_W), .MAX_DIV_LOG2(MAX_DIV_LOG2),
        .BPF_LO_LOG2(BPF_LO_LOG2), .BPF_HI_LOG2(BPF_HI_LOG2)
    ) u_decode (
        .mode(mode_q), .div_log2(div_log2_q), .bpf_hi(bpf_q), .fs(fs_q),
        .div(bit_div), .err(cfg_bad)
    );

    assign run = !cfg_bad;

    aclk_phase_ctr #(.W(FS_W)) u_bit_ctr (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(cfg_load),
        .period(bit_div), .at_zero(b_zero), .at_half(b_half), .upper(b_upper)
    );

    aclk_phase_ctr #(.W(FS_W)) u_frame_ctr (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(cfg_load),
        .period(fs_q), .at_zero(f_zero), .at_half(f_half), .upper(f_upper)
    );

    // Map the phase points onto the clock outputs (all low while idle).
    always_comb begin
        bclk          = b_upper;
        bclk_fall_stb = b_zero;
        bclk_rise_stb = b_half;
        lrc           = f_upper;
        frame_stb     = f_zero;
        half_stb      = f_half;
        config_error  = cfg_bad;
    end

    // R6: frame boundaries sit on a BCLK falling strobe
    p_frame_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb || half_stb) |-> bclk_fall_stb);

    // R5: LRC changes only at a frame or half-frame boundary
    p_lrc_moves_on_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> ((lrc == $past(lrc)) || frame_stb || half_stb));

    // R4: a divisor of one strobes both edges every cycle
    p_div_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && bit_div == FS_W'(1)) |-> (bclk && bclk_fall_stb && bclk_rise_stb));

    // R9: an inconsistent configuration silences every output
    p_idle_on_error_r9: assert property (@(posedge clk) disable iff (!rst_n)
        config_error |-> !(bclk || bclk_fall_stb || bclk_rise_stb ||
                           lrc || frame_stb || half_stb));

    // R10: the first cycle after a load starts a frame with LRC low
    p_load_restarts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (!lrc && (config_error || frame_stb)));

    // R11: the error flag cannot change without a load
    p_hold_without_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(config_error));

endmodule

// File: tb/audio_clkgen_bench.sv
// Sweeps divide and multiply configurations over a set of FS ratios.
// Every output is compared cycle by cycle with arithmetic expectations.
module audio_clkgen_bench;
    localparam int FS_W = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_load = 1'b0;
    logic            cfg_mode = 1'b0;
    logic [2:0]      cfg_div_log2 = 3'd0;
    logic            cfg_bpf64 = 1'b0;
    logic [FS_W-1:0] cfg_fs = '0;
    logic bclk, bclk_fall_stb, bclk_rise_stb, lrc, frame_stb, half_stb, config_error;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    audio_clkgen u_audio_clkgen (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
        .cfg_div_log2(cfg_div_log2), .cfg_bpf64(cfg_bpf64), .cfg_fs(cfg_fs),
        .bclk(bclk), .bclk_fall_stb(bclk_fall_stb), .bclk_rise_stb(bclk_rise_stb),
        .lrc(lrc), .frame_stb(frame_stb), .half_stb(half_stb),
        .config_error(config_error)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Load one configuration and compare the outputs for about one and a half frames.
    task automatic run_cfg(input int m, input int s, input int b, input int fs, input bit scramble);
        int d, bpf, n;
        bit err;
        string btag;
        @(negedge clk);
        cfg_load = 1'b1; cfg_mode = m[0]; cfg_div_log2 = s[2:0];
        cfg_bpf64 = b[0]; cfg_fs = fs[FS_W-1:0];
        @(negedge clk);
        cfg_load = 1'b0;
        bpf = b ? 64 : 32;
        d   = m ? fs / bpf : (1 << s);
        err = (fs == 0) || (fs % 2 != 0);
        if (m == 0) err = err || (s > 4) || ((fs / 2) % d != 0);
        else        err = err || (fs % bpf != 0);
        check(m ? "R8 error flag" : "R7 error flag", {7'd0, config_error}, {7'd0, err});
        btag = err ? "R9" : (d == 1 ? "R4" : (m ? "R3" : "R2"));
        n = err ? 8 : fs + fs / 2 + 4;
        for (int k = 0; k < n; k++) begin
            logic [2:0] bexp, fexp;
            string bt, ft;
            if (err) begin
                bexp = 3'b000; fexp = 3'b000;
            end else begin
                bexp = {(k % d) >= d / 2, (k % d) == 0, (k % d) == d / 2};
                fexp = {(k % fs) >= fs / 2, (k % fs) == 0, (k % fs) == fs / 2};
            end
            bt = (scramble && k > 3) ? "R11 bit" : btag;
            ft = (scramble && k > 3) ? "R11 frame" : (err ? "R9" : "R5");
            check(bt, {5'd0, bclk, bclk_fall_stb, bclk_rise_stb}, {5'd0, bexp});
            check(ft, {5'd0, lrc, frame_stb, half_stb}, {5'd0, fexp});
            if (k == 0)
                check("R10 restart", {6'd0, lrc, frame_stb}, {6'd0, 1'b0, !err});
            if (frame_stb || half_stb)
                check("R6 boundary on fall", {7'd0, bclk_fall_stb}, 8'd1);
            if (scramble && k == 3) begin
                cfg_mode = ~m[0]; cfg_div_log2 = 3'd7; cfg_bpf64 = ~b[0]; cfg_fs = 12'd6;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        int fsl[10] = '{128, 192, 256, 272, 1536, 6, 255, 96, 32, 0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: default configuration, divisor 4 and FS 256
        for (int k = 0; k < 8; k++) begin
            check("R1 default bit", {5'd0, bclk, bclk_fall_stb, bclk_rise_stb},
                  {5'd0, (k % 4) >= 2, (k % 4) == 0, (k % 4) == 2});
            check("R1 default frame", {4'd0, config_error, lrc, frame_stb, half_stb},
                  {4'd0, 1'b0, 1'b0, k == 0, 1'b0});
            @(negedge clk);
        end
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < (m ? 2 : 6); s++)
                for (int i = 0; i < 10; i++)
                    run_cfg(m, m ? 0 : s, m ? s : 0, fsl[i], i == 2);
        // Recover from an error into a valid configuration
        run_cfg(0, 1, 0, 272, 1'b0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule